// File: doc/BRIEF.md
# Common-Boundary Bank MMU

This block translates the 16-bit logical address of an 8-bit CPU into a 20-bit physical memory address. The logical space is cut into sixteen 4 KB pages. A programmable boundary page splits it into two parts. Pages at or above the boundary form common memory, which always maps to the same low physical region. Pages below the boundary are banked: a bank base is added to the page number, so any run of physical pages can appear under the banked window.

Two bank bases are kept. One applies to memory reads and one to memory writes. With both bases equal, the block behaves as a single bank switch. With different values, a block-move loop reads from one bank and writes to another without a staging buffer in common memory. All three registers are loaded by CPU I/O writes. The port number comes from the low address byte. A fourth port loads both bases at once, so a normal bank change costs one OUT instruction.

An option replaces the boundary register with a fixed value. Boards with a hard-wired common size use this option.

Top module: `bank_mmu`

## Requirements
- R1: After reset, the boundary and both bases are 0. Every logical address then maps to the same physical address with the top 4 bits zero, and `common_sel` is 1.
- R2: An access is common exactly when the logical page A15:A12 is greater than or equal to the boundary. A boundary of 0 makes all memory common.
- R3: A banked access produces the physical address {(base + page) modulo 256, A11:A0}. Any carry out of the 8-bit sum is dropped.
- R4: A common access produces the physical address {4'h0, A15:A0}, whatever the bases hold.
- R5: The write base is applied while `wr_n` is low. The read base is applied at all other times.
- R6: On a rising clock edge with `iorq_n` and `wr_n` both low, the block decodes the port number on A7:A0. Port 0x70 loads the boundary from data bits 3:0. Port 0x71 loads the read base from the 8 data bits. Port 0x72 loads the write base from the 8 data bits.
- R7: An I/O write to port 0x73 loads both bases from the data byte in one write.
- R8: The registers are left unchanged by an I/O write to any other port number, and by `wr_n` low while `iorq_n` is high.
- R9: With the fixed-boundary option set, the boundary always equals the configured value, including during reset, and writes to port 0x70 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU logical address. A7:A0 carry the port number during I/O cycles |
| cpu_data | input | 8 | CPU write data for register loads |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| phys_addr | output | 20 | Translated physical address |
| common_sel | output | 1 | High when the access falls in common memory |

## Verification
A corrupted base or boundary register does not stay hidden. The next memory access in the affected page range shows it at once on `phys_addr`, in the same cycle and with no pipeline delay. A wrong boundary appears as `common_sel` switching at the wrong page and as a zero top nibble where a relocated page was expected. A base that was loaded into the wrong register shows as a mismatch between read and write translations of the same address. A decode fault on the ports becomes visible on the first access after the faulty I/O write. For that reason every page is swept in both directions after each boundary change.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;

   // Register load selected by an I/O write cycle
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_BOUND,
      SEL_RBASE,
      SEL_WBASE,
      SEL_BOTH
   } mmu_sel_e;

endpackage

// File: rtl/mmu_port_decode.sv
module mmu_port_decode
   import bank_mmu_pkg::*;
#(
   parameter int          PORT_W      = 8,
   parameter logic [7:0]  PORT_BOUND  = 8'h70,
   parameter logic [7:0]  PORT_RBASE  = 8'h71,
   parameter logic [7:0]  PORT_WBASE  = 8'h72,
   parameter logic [7:0]  PORT_BOTH   = 8'h73
) (
   input  logic              iorq_n,
   input  logic              wr_n,
   input  logic [PORT_W-1:0] port,
   output mmu_sel_e          sel
);

   logic io_wr;
   assign io_wr = !iorq_n && !wr_n;

   always_comb begin
      sel = SEL_NONE;
      if (io_wr) begin
         if (port == PORT_W'(PORT_BOUND))      sel = SEL_BOUND;
         else if (port == PORT_W'(PORT_RBASE)) sel = SEL_RBASE;
         else if (port == PORT_W'(PORT_WBASE)) sel = SEL_WBASE;
         else if (port == PORT_W'(PORT_BOTH))  sel = SEL_BOTH;
      end
   end

endmodule

// File: rtl/mmu_bank_regs.sv
module mmu_bank_regs
   import bank_mmu_pkg::*;
#(
   parameter int PAGE_W         = 4,
   parameter int BASE_W         = 8,
   parameter bit FIXED_BOUNDARY = 1'b0,
   parameter int BOUNDARY_INIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mmu_sel_e          sel,
   input  logic [BASE_W-1:0] data,
   output logic [PAGE_W-1:0] boundary,
   output logic [BASE_W-1:0] rd_base,
   output logic [BASE_W-1:0] wr_base
);

   localparam logic [PAGE_W-1:0] BOUND_RST =
      FIXED_BOUNDARY ? PAGE_W'(BOUNDARY_INIT) : '0;

   generate
      if (FIXED_BOUNDARY) begin : g_fixed_bound
         assign boundary = BOUND_RST;
      end else begin : g_prog_bound
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 boundary <= '0;
            else if (sel == SEL_BOUND)  boundary <= data[PAGE_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_base <= '0;
         wr_base <= '0;
      end else begin
         if (sel == SEL_RBASE || sel == SEL_BOTH) rd_base <= data;
         if (sel == SEL_WBASE || sel == SEL_BOTH) wr_base <= data;
      end
   end

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_base == '0 && wr_base == '0 && boundary == BOUND_RST));

   assert_rbase_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_RBASE) |=> (rd_base == $past(data) && $stable(wr_base)));

   assert_wbase_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_WBASE) |=> (wr_base == $past(data) && $stable(rd_base)));

   assert_both_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_BOTH) |=> (rd_base == $past(data) && wr_base == $past(data)));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |=> ($stable(rd_base) && $stable(wr_base) && $stable(boundary)));

   assert_fixed_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (FIXED_BOUNDARY && sel == SEL_BOUND) |=> $stable(boundary));

endmodule

// File: rtl/mmu_translate.sv
module mmu_translate #(
   parameter int PAGE_W = 4,
   parameter int OFFS_W = 12,
   parameter int BASE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PAGE_W-1:0]        page,
   input  logic [OFFS_W-1:0]        offset,
   input  logic [PAGE_W-1:0]        boundary,
   input  logic [BASE_W-1:0]        base,
   output logic [BASE_W+OFFS_W-1:0] phys,
   output logic                     common
);

   localparam int PHYS_W = BASE_W + OFFS_W;

   logic [BASE_W-1:0] reloc_page;
   logic [BASE_W-1:0] ppage;

   // Magnitude compare against the boundary page
   assign common = (page >= boundary);

   // Relocation adder; width truncation discards the carry
   generate
      if (BASE_W == PAGE_W) begin : g_same_width
         assign reloc_page = base + page;
      end else begin : g_wide_base
         assign reloc_page = base + {{(BASE_W-PAGE_W){1'b0}}, page};
      end
   endgenerate

   assign ppage = common ? BASE_W'(page) : reloc_page;
   assign phys  = {ppage, offset};

   assert_zero_bound_common_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary == '0) |-> common);

   assert_banked_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !common |-> (page < boundary));

   assert_common_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
      common |-> ((phys >> OFFS_W) == PHYS_W'(page) && phys[OFFS_W-1:0] == offset));

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
   import bank_mmu_pkg::*;
#(
   parameter int         LOG_W          = 16,
   parameter int         PAGE_W         = 4,
   parameter int         BASE_W         = 8,
   parameter int         PORT_W         = 8,
   parameter logic [7:0] PORT_BOUND     = 8'h70,
   parameter logic [7:0] PORT_RBASE     = 8'h71,
   parameter logic [7:0] PORT_WBASE     = 8'h72,
   parameter logic [7:0] PORT_BOTH      = 8'h73,
   parameter bit         FIXED_BOUNDARY = 1'b0,
   parameter int         BOUNDARY_INIT  = 0,
   localparam int        OFFS_W         = LOG_W - PAGE_W,
   localparam int        PHYS_W         = BASE_W + OFFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOG_W-1:0]  cpu_addr,
   input  logic [BASE_W-1:0] cpu_data,
   input  logic              iorq_n,
   input  logic              wr_n,
   output logic [PHYS_W-1:0] phys_addr,
   output logic              common_sel
);

   initial begin
      if (BASE_W < PAGE_W)
         $error("bank_mmu: base width must cover the page number");
      if (PORT_W > OFFS_W)
         $error("bank_mmu: port number must fit in the page offset bits");
      if (PORT_BOUND == PORT_RBASE || PORT_BOUND == PORT_WBASE ||
          PORT_BOUND == PORT_BOTH  || PORT_RBASE == PORT_WBASE ||
          PORT_RBASE == PORT_BOTH  || PORT_WBASE == PORT_BOTH)
         $error("bank_mmu: register ports must be distinct");
      if (BOUNDARY_INIT < 0 || BOUNDARY_INIT >= (1 << PAGE_W))
         $error("bank_mmu: fixed boundary out of range");
   end

   mmu_sel_e          sel;
   logic [PAGE_W-1:0] boundary;
   logic [BASE_W-1:0] rd_base;
   logic [BASE_W-1:0] wr_base;
   logic [BASE_W-1:0] act_base;

   mmu_port_decode #(
      .PORT_W     (PORT_W),
      .PORT_BOUND (PORT_BOUND),
      .PORT_RBASE (PORT_RBASE),
      .PORT_WBASE (PORT_WBASE),
      .PORT_BOTH  (PORT_BOTH)
   ) i_decode (
      .iorq_n (iorq_n),
      .wr_n   (wr_n),
      .port   (cpu_addr[PORT_W-1:0]),
      .sel    (sel)
   );

   mmu_bank_regs #(
      .PAGE_W         (PAGE_W),
      .BASE_W         (BASE_W),
      .FIXED_BOUNDARY (FIXED_BOUNDARY),
      .BOUNDARY_INIT  (BOUNDARY_INIT)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .data     (cpu_data),
      .boundary (boundary),
      .rd_base  (rd_base),
      .wr_base  (wr_base)
   );

   // Write cycles relocate through the write base, all others the read base
   assign act_base = wr_n ? rd_base : wr_base;

   mmu_translate #(
      .PAGE_W (PAGE_W),
      .OFFS_W (OFFS_W),
      .BASE_W (BASE_W)
   ) i_xlate (
      .clk      (clk),
      .rst_n    (rst_n),
      .page     (cpu_addr[LOG_W-1:OFFS_W]),
      .offset   (cpu_addr[OFFS_W-1:0]),
      .boundary (boundary),
      .base     (act_base),
      .phys     (phys_addr),
      .common   (common_sel)
   );

   assert_equal_bases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_base == wr_base && $stable(cpu_addr) && $stable(rd_base) && $stable(wr_base)
       && $stable(boundary)) |-> $stable(phys_addr));

endmodule

// File: tb/test_bank_mmu.sv
module test_bank_mmu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        iorq_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [19:0] phys_addr, phys_fx;
   logic        common_sel, common_fx;

   int n_checks = 0;
   int n_fail   = 0;

   // Bench model of register contents
   int m_bound = 0;
   int m_rb    = 0;
   int m_wb    = 0;

   always #10 clk = ~clk;

   bank_mmu i_bank_mmu (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .iorq_n(iorq_n), .wr_n(wr_n), .phys_addr(phys_addr), .common_sel(common_sel)
   );

   bank_mmu #(.FIXED_BOUNDARY(1'b1), .BOUNDARY_INIT(8)) i_bank_mmu_fixed (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .iorq_n(iorq_n), .wr_n(wr_n), .phys_addr(phys_fx), .common_sel(common_fx)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int exp_phys(input int addr, input bit wr, input int bnd,
                                   input int rb, input int wb);
      int page = (addr >> 12) & 15;
      int base = wr ? wb : rb;
      if (page >= bnd) return addr & 16'hFFFF;
      return (((base + page) % 256) << 12) | (addr & 12'hFFF);
   endfunction

   task automatic io_write(input int port, input int data);
      @(negedge clk);
      cpu_addr = 16'(port);
      cpu_data = 8'(data);
      iorq_n   = 1'b0;
      wr_n     = 1'b0;
      @(negedge clk);
      iorq_n   = 1'b1;
      wr_n     = 1'b1;
   endtask

   // Drive a memory access and compare both instances against the model
   task automatic access(input string req, input int addr, input bit wr);
      @(negedge clk);
      cpu_addr = 16'(addr);
      wr_n     = !wr;
      #2;
      chk(req, int'(phys_addr), exp_phys(addr, wr, m_bound, m_rb, m_wb));
      chk(req, int'(common_sel), int'(((addr >> 12) & 15) >= m_bound));
      chk({req, "/R9"}, int'(phys_fx), exp_phys(addr, wr, 8, m_rb, m_wb));
      chk({req, "/R9"}, int'(common_fx), int'(((addr >> 12) & 15) >= 8));
      wr_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: identity map after reset (fixed instance boundary 8, bases 0)
      access("R1", 16'h0000, 1'b0);
      access("R1", 16'h7ABC, 1'b0);
      access("R1", 16'hFFFF, 1'b1);
      access("R1", 16'h3456, 1'b1);

      // R6: individual register loads; only data bits 3:0 reach the boundary
      io_write(8'h71, 8'h25); m_rb = 8'h25;
      io_write(8'h72, 8'h40); m_wb = 8'h40;
      io_write(8'h70, 8'hAC); m_bound = 12;
      access("R6", 16'h3123, 1'b0);
      access("R6", 16'h3123, 1'b1);
      access("R6", 16'hC001, 1'b0);

      // R7: one write sets both bases
      io_write(8'h73, 8'h9A); m_rb = 8'h9A; m_wb = 8'h9A;
      access("R7", 16'h5555, 1'b0);
      access("R7", 16'h5555, 1'b1);

      // R8: foreign port and memory write leave registers unchanged
      io_write(8'h74, 8'h11);
      io_write(8'h6F, 8'h11);
      @(negedge clk);
      cpu_addr = 16'h0071; cpu_data = 8'h33; wr_n = 1'b0;
      @(negedge clk);
      cpu_addr = 16'h0070; cpu_data = 8'h00;
      @(negedge clk);
      wr_n = 1'b1;
      access("R8", 16'h2000, 1'b0);
      access("R8", 16'hB0F0, 1'b1);
      access("R8", 16'hC000, 1'b0);

      // R2..R5 and R9: sweep every boundary, page and direction
      for (int b = 0; b < 16; b++) begin
         io_write(8'h70, b);          m_bound = b;
         io_write(8'h71, b * 17 + 3); m_rb = (b * 17 + 3) % 256;
         io_write(8'h72, 8'hF0 + b);  m_wb = 8'hF0 + b;
         for (int p = 0; p < 16; p++) begin
            int a = (p << 12) | ((p * 16'h111 + b * 7) & 12'hFFF);
            access((p >= b) ? "R2/R4" : "R2/R3", a, 1'b0);
            access("R3/R5", a, 1'b1);
         end
      end

      // R3: carry out of the adder is dropped
      io_write(8'h70, 8'h0F); m_bound = 15;
      io_write(8'h73, 8'hFF); m_rb = 8'hFF; m_wb = 8'hFF;
      access("R3", 16'h3ABC, 1'b0);
      chk("R3", int'(phys_addr), 20'h02ABC);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule